// File: doc/BRIEF.md
# Trimmed One-Second Divider

This block turns a nominal 32,768 Hz clock-enable into a one-clock pulse per second. In place of analog crystal trimming, it shortens or lengthens chosen seconds by a whole number of input counts. A signed code selects the correction. A built-in minute counter steps through a repeating 64-minute pattern, and the correction lands on the first second of each minute early in that pattern. A separate free-running divider produces a 512 Hz square wave. This square wave lets production equipment measure the raw oscillator, and calibration never changes its frequency.

The calibration code has 6 bits. Bits 4:0 give a magnitude N from 0 to 31, and bit 5 gives the direction: 1 speeds the clock up and 0 slows it down. A positive step removes 256 input counts from one second, and 512 counts over the whole pattern. A negative step adds 128 counts to one second, and 256 counts over the pattern. A run input freezes the second divider and the minute sequencing without clearing them.

Top module: `osc_trim_divider`

## Requirements
- R1: While reset is asserted and right after it, `sec_tick` and `test_sq` are 0.
- R2: With magnitude 0, every second lasts exactly 2^DIV_LOG2 counted enables (32,768 by default). A counted enable is a clock with both `osc_en` and `run` high.
- R3: With bit 5 = 1 and a non-zero magnitude, each altered second lasts 2^DIV_LOG2 - 2^STAGE_LOG2 counted enables (32,512 by default).
- R4: With bit 5 = 0 and a non-zero magnitude, each altered second lasts 2^DIV_LOG2 + 2^(STAGE_LOG2-1) counted enables (32,896 by default).
- R5: A second is altered only if it is the first second of its minute and that minute's index within the 64-minute pattern is below 2×magnitude. This gives at most 62 altered minutes, with minute 0 as the first. All other seconds are nominal.
- R6: The minute index advances once per SEC_PER_MIN seconds and wraps from 63 to 0, so the pattern repeats every 64 minutes, starting at minute 0 after reset.
- R7: While `run` is low, enables are not counted, the second position and minute index hold, and no tick is produced. Counting resumes where it stopped.
- R8: The calibration code is captured at the first counted enable of each second and governs that whole second. Changes made later in the second take effect from the next second.
- R9: `test_sq` is bit TEST_LOG2-1 of a count of all `osc_en` pulses since reset, so it toggles every 32 pulses by default (512 Hz). `run` and the calibration code have no effect on it.
- R10: `sec_tick` is high for exactly one clock, in the clock that follows the final counted enable of a second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-clock enable at the oscillator rate |
| run | input | 1 | Counting permitted when high |
| cal_code | input | 6 | Bit 5 direction (1 faster), bits 4:0 magnitude |
| sec_tick | output | 1 | One-clock pulse at the end of each second |
| test_sq | output | 1 | Square wave at 1/2^TEST_LOG2 of the enable rate |

## Verification
The assertions hold on every cycle for the timing relations. A tick needs a counted enable on the clock before it and never lasts two clocks. The second counter and minute index stay frozen while `run` is low, and the minute index moves only on a tick. The test wave is still on clocks without an enable, and the second counter stays below the longest second. The bench scenarios cover what depends on history: exact lengths of nominal, shortened and lengthened seconds, which minutes of the 64-minute pattern are altered, wrap-around into a new pattern, the point in a second at which a code change applies, and the test wave's phase under random enables.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

   localparam int unsigned CAL_W = 6;
   localparam int unsigned MAG_W = 5;

   typedef struct packed {
      logic              faster;
      logic [MAG_W-1:0]  mag;
   } trim_code_t;

   // minute lies inside the correction window of a magnitude
   function automatic logic in_window(input int unsigned minute,
                                      input logic [MAG_W-1:0] mag);
      return minute < (32'(mag) << 1);
   endfunction

endpackage

// File: rtl/otd_second_div.sv
module otd_second_div #(
   parameter int unsigned DIV_LOG2   = 15,
   parameter int unsigned STAGE_LOG2 = 8,
   localparam int unsigned CW        = DIV_LOG2 + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          alter,
   input  logic          faster,
   output logic [CW-1:0] cnt,
   output logic          first,
   output logic          done
);

   localparam int unsigned NOM_LEN   = 1 << DIV_LOG2;
   localparam int unsigned SHORT_LEN = NOM_LEN - (1 << STAGE_LOG2);
   localparam int unsigned LONG_LEN  = NOM_LEN + (1 << (STAGE_LOG2 - 1));

   logic [CW-1:0] last_q;

   always_comb begin
      if (!alter)      last_q = CW'(NOM_LEN - 1);
      else if (faster) last_q = CW'(SHORT_LEN - 1);
      else             last_q = CW'(LONG_LEN - 1);
   end

   assign first = step && (cnt == '0);
   assign done  = step && (cnt == last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (done) cnt <= '0;
      else if (step) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/otd_minute_seq.sv
module otd_minute_seq #(
   parameter int unsigned SEC_PER_MIN = 60,
   parameter int unsigned MIN_LOG2    = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                advance,
   output logic                first_sec,
   output logic [MIN_LOG2-1:0] min_idx
);

   localparam int unsigned SW = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;

   logic min_adv;

   generate
      if (SEC_PER_MIN == 1) begin : g_one
         assign first_sec = 1'b1;
         assign min_adv   = advance;
      end else begin : g_cnt
         localparam logic [SW-1:0] LAST_SEC = SW'(SEC_PER_MIN - 1);
         logic [SW-1:0] sec_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sec_q <= '0;
            else if (advance) sec_q <= (sec_q == LAST_SEC) ? '0 : sec_q + 1'b1;
         end
         assign first_sec = (sec_q == '0);
         assign min_adv   = advance && (sec_q == LAST_SEC);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       min_idx <= '0;
      else if (min_adv) min_idx <= min_idx + 1'b1;
   end

endmodule

// File: rtl/otd_trim_select.sv
module otd_trim_select
   import osc_trim_pkg::*;
#(
   parameter int unsigned MIN_LOG2 = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [CAL_W-1:0]    cal_code,
   input  logic                first_sec,
   input  logic [MIN_LOG2-1:0] min_idx,
   output logic                alter,
   output logic                faster
);

   trim_code_t code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    code_q <= '0;
      else if (load) code_q <= trim_code_t'(cal_code);
   end

   always_comb begin
      alter  = first_sec && (code_q.mag != '0) &&
               in_window(32'(min_idx), code_q.mag);
      faster = code_q.faster;
   end

endmodule

// File: rtl/otd_test_wave.sv
module otd_test_wave #(
   parameter int unsigned TEST_LOG2 = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_en,
   output logic wave
);

   logic [TEST_LOG2-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= '0;
      else if (osc_en) div_q <= div_q + 1'b1;
   end

   assign wave = div_q[TEST_LOG2-1];

endmodule

// File: rtl/osc_trim_divider.sv
module osc_trim_divider
   import osc_trim_pkg::*;
#(
   parameter int unsigned DIV_LOG2    = 15,
   parameter int unsigned STAGE_LOG2  = 8,
   parameter int unsigned SEC_PER_MIN = 60,
   parameter int unsigned MIN_LOG2    = 6,
   parameter int unsigned TEST_LOG2   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_en,
   input  logic             run,
   input  logic [CAL_W-1:0] cal_code,
   output logic             sec_tick,
   output logic             test_sq
);

   localparam int unsigned CW = DIV_LOG2 + 1;

   generate
      if (STAGE_LOG2 < 1 || STAGE_LOG2 >= DIV_LOG2) begin : g_bad_stage
         $error("correction stage must lie inside the divider");
      end
      if (MIN_LOG2 < 6) begin : g_bad_min
         $error("minute pattern must hold at least 64 minutes");
      end
      if (SEC_PER_MIN < 1) begin : g_bad_spm
         $error("a minute needs at least one second");
      end
      if (TEST_LOG2 < 1 || TEST_LOG2 > DIV_LOG2) begin : g_bad_test
         $error("test wave divider out of range");
      end
   endgenerate

   logic                step;
   logic                sec_first;
   logic                sec_done;
   logic                alter;
   logic                faster;
   logic                first_sec;
   logic [MIN_LOG2-1:0] min_idx;
   logic [CW-1:0]       sec_cnt;

   assign step = osc_en && run;

   otd_second_div #(
      .DIV_LOG2   (DIV_LOG2),
      .STAGE_LOG2 (STAGE_LOG2)
   ) u_sec (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step),
      .alter  (alter),
      .faster (faster),
      .cnt    (sec_cnt),
      .first  (sec_first),
      .done   (sec_done)
   );

   otd_minute_seq #(
      .SEC_PER_MIN (SEC_PER_MIN),
      .MIN_LOG2    (MIN_LOG2)
   ) u_min (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (sec_done),
      .first_sec (first_sec),
      .min_idx   (min_idx)
   );

   otd_trim_select #(
      .MIN_LOG2 (MIN_LOG2)
   ) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sec_first),
      .cal_code  (cal_code),
      .first_sec (first_sec),
      .min_idx   (min_idx),
      .alter     (alter),
      .faster    (faster)
   );

   otd_test_wave #(
      .TEST_LOG2 (TEST_LOG2)
   ) u_wave (
      .clk    (clk),
      .rst_n  (rst_n),
      .osc_en (osc_en),
      .wave   (test_sq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sec_tick <= 1'b0;
      else        sec_tick <= sec_done;
   end

endmodule

// File: rtl/osc_trim_chk.sv
module osc_trim_chk #(
   parameter int unsigned CW       = 16,
   parameter int unsigned MW       = 6,
   parameter int unsigned LONG_LEN = 32896
) (
   input logic          clk,
   input logic          rst_n,
   input logic          osc_en,
   input logic          run,
   input logic          sec_tick,
   input logic          test_sq,
   input logic [CW-1:0] cnt,
   input logic [MW-1:0] min_idx
);

   // R10: a tick follows a counted enable on the previous clock
   a_r10_tick_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |-> $past(osc_en && run));

   // R10: a tick lasts one clock
   a_r10_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> !sec_tick);

   // R7: the second counter is frozen while run is low
   a_r7_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt));

   // R7: the minute index is frozen while run is low
   a_r7_hold_minute: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(min_idx));

   // R6: the minute index moves only together with a tick
   a_r6_minute_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (min_idx != $past(min_idx)) |-> sec_tick);

   // R9: the test wave changes only after an oscillator enable
   a_r9_test_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |=> $stable(test_sq));

   // R4: no second runs beyond the longest allowed length
   a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) < LONG_LEN);

endmodule

bind osc_trim_divider osc_trim_chk #(
   .CW       (DIV_LOG2 + 1),
   .MW       (MIN_LOG2),
   .LONG_LEN ((1 << DIV_LOG2) + (1 << (STAGE_LOG2 - 1)))
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .osc_en   (osc_en),
   .run      (run),
   .sec_tick (sec_tick),
   .test_sq  (test_sq),
   .cnt      (sec_cnt),
   .min_idx  (min_idx)
);

// File: tb/osc_trim_divider_test.sv
`timescale 1ns/1ps
module osc_trim_divider_test;

   localparam int D   = 7;
   localparam int S   = 3;
   localparam int SPM = 3;
   localparam int T   = 6;
   localparam int NOM   = 1 << D;
   localparam int SHORT = NOM - (1 << S);
   localparam int LONG  = NOM + (1 << (S - 1));
   localparam int SECS_PER_CYCLE = 64 * SPM;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_en = 1'b0;
   logic       run = 1'b0;
   logic [5:0] cal_code = '0;
   logic       sec_tick;
   logic       test_sq;

   int checks = 0;
   int errors = 0;
   bit done_flag = 0;

   int         cnt_b = 0;
   int         sec_idx = 0;
   int         total_en = 0;
   int         tick_total = 0;
   logic [5:0] cap = '0;
   bit         tick_prev = 0;
   string      phase_tag = "";

   always #2.5 clk = ~clk;

   osc_trim_divider #(
      .DIV_LOG2    (D),
      .STAGE_LOG2  (S),
      .SEC_PER_MIN (SPM),
      .MIN_LOG2    (6),
      .TEST_LOG2   (T)
   ) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .osc_en   (osc_en),
      .run      (run),
      .cal_code (cal_code),
      .sec_tick (sec_tick),
      .test_sq  (test_sq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, phase_tag, act, expv);
      end
   endtask

   // expected length of second number idx of the pattern, from R2..R5
   function automatic int exp_len(input int idx, input logic [5:0] cal);
      int mag = int'(cal[4:0]);
      int pos = idx % SECS_PER_CYCLE;
      if (mag != 0 && (pos % SPM) == 0 && (pos / SPM) < 2 * mag)
         return cal[5] ? SHORT : LONG;
      return NOM;
   endfunction

   function automatic string len_tag(input int len, input logic [5:0] cal, input int idx);
      if (idx > 0 && (idx % SECS_PER_CYCLE) == 0 && len != NOM) return "R6";
      if (len == SHORT) return "R3";
      if (len == LONG)  return "R4";
      if (cal[4:0] == 5'd0) return "R2";
      return "R5";
   endfunction

   // counted enables and the code captured at the first one (R8)
   always @(posedge clk) begin
      if (rst_n) begin
         if (osc_en) total_en++;
         if (osc_en && run) begin
            if (cnt_b == 0) cap = cal_code;
            cnt_b++;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         chk(test_sq == ((total_en >> (T - 1)) & 1), "R9", int'(test_sq),
             (total_en >> (T - 1)) & 1);
         if (sec_tick) begin
            int e;
            e = exp_len(sec_idx, cap);
            chk(cnt_b == e, len_tag(e, cap, sec_idx), cnt_b, e);
            chk(!tick_prev, "R10", int'(tick_prev), 0);
            sec_idx++;
            tick_total++;
            cnt_b = 0;
         end
         tick_prev = sec_tick;
      end
   end

   task automatic summary;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (200000 - 5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      done_flag = 1;
      summary();
      $finish;
   end

   initial begin
      int t0;
      void'($urandom(32'd2718));
      repeat (4) @(negedge clk);
      chk(sec_tick == 1'b0, "R1", int'(sec_tick), 0);
      chk(test_sq == 1'b0, "R1", int'(test_sq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sec_tick == 1'b0, "R1", int'(sec_tick), 0);

      // nominal seconds
      phase_tag = "(R2 nominal)";
      cal_code = 6'b000000;
      run = 1'b1;
      osc_en = 1'b1;
      repeat (10 * NOM + 40) @(negedge clk);

      // run held low in mid-second with enables present
      phase_tag = "(R7 hold)";
      t0 = tick_total;
      run = 1'b0;
      repeat (300) @(negedge clk);
      chk(tick_total == t0, "R7", tick_total - t0, 0);
      run = 1'b1;
      repeat (3 * NOM) @(negedge clk);

      // positive magnitude 5 over more than one full pattern
      phase_tag = "(R3 +5)";
      cal_code = 6'b100101;
      repeat (SECS_PER_CYCLE * NOM + 4 * NOM) @(negedge clk);

      // negative magnitude 31 over a full pattern
      phase_tag = "(R4 -31)";
      cal_code = 6'b011111;
      repeat (SECS_PER_CYCLE * LONG) @(negedge clk);

      // positive magnitude 31
      phase_tag = "(R5 +31)";
      cal_code = 6'b111111;
      repeat (SECS_PER_CYCLE * NOM / 2) @(negedge clk);

      // random enables, run gaps and code changes at any point (R8)
      phase_tag = "(R8 random)";
      for (int i = 0; i < 60000; i++) begin
         @(negedge clk);
         osc_en = ($urandom % 4) != 0;
         run = ($urandom % 50) != 0;
         if (($urandom % 300) == 0) cal_code = 6'($urandom);
      end
      run = 1'b1;
      osc_en = 1'b1;
      repeat (2 * LONG) @(negedge clk);

      done_flag = 1;
      chk(sec_idx > SECS_PER_CYCLE, "R6", sec_idx, SECS_PER_CYCLE + 1);
      summary();
      $finish;
   end

endmodule